// File: doc/BRIEF.md
# Two-Strike Watchdog with Interrupt-Driven Flag Servicing

This block is a countdown watchdog that does not reset the system on its first timeout. Each time the counter runs out it raises an expiry flag and starts counting again. The reset output only fires when the counter runs out a second time while that flag is still set. The flag can be cleared in two ways. Software can write one to it, normally when it kicks the timer. A management-interrupt path can also clear it automatically, standing in for firmware that keeps the machine alive until an operating system takes over.

The interrupt path is enabled out of reset. Software turns it off through a control bit to take ownership of the flag before it arms the timer. If the interrupt handler stops servicing its request, the flag stays set and the second expiry resets the system. With a timeout of T ticks, a hang is detected after at least T ticks and at most 2T ticks.

A free-running timebase supplies one-cycle `tick` pulses. `kick` restarts the countdown. A small word-addressed register port holds the arm bit, the status flag, the timeout, the interrupt-clear enable and a read-only view of the counter.

Top module: `twostrike_wdog`

## Requirements
- R1: After `rstN` is released, `sysRst` and `smiReq` are low, the arm bit (offset 0x00, bit 0) reads 0, the status flag reads 0, the timeout (offset 0x08) and the counter (offset 0x10) read `DEF_TIMEOUT`, and the interrupt-clear enable (offset 0x0C, bit 13) reads 1.
- R2: Writing 1 to bit 0 at offset 0x00 while disarmed loads the counter with the timeout. While armed, each `tick` lowers the counter by one. The tick that finds the counter at 1 is an expiry: it reloads the counter and sets the expiry flag, which is bit 3 of the status word at offset 0x04. An expiry therefore occurs every T ticks.
- R3: A write to offset 0x04 with bit 3 set clears the expiry flag. A write with bit 3 clear leaves the flag unchanged, whatever the other bits hold.
- R4: An expiry while the flag is already set drives `sysRst` high from the clock edge of that tick, for exactly `RST_CYCLES` cycles.
- R5: `kick` reloads the counter with the timeout. It takes priority over a tick in the same cycle and leaves the expiry flag unchanged.
- R6: While bit 13 at offset 0x0C is 1, every expiry raises `smiReq` for one cycle. In that cycle, if `smiSvcOk` is high, the flag is cleared at the next edge. A serviced watchdog therefore never resets.
- R7: While `smiSvcOk` is low the automatic clear does not happen. The flag stays set, and the next expiry resets the system.
- R8: When the reset pulse ends, the arm bit is 0, the flag is 0, the interrupt-clear enable is 1, and the timeout and the counter are back at `DEF_TIMEOUT`.
- R9: While disarmed, ticks leave the counter unchanged. While `sysRst` is high, register writes have no effect.
- R10: A timeout of 0 behaves as a timeout of 1: every tick is an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase pulse |
| kick | input | 1 | Reload strobe for the counter |
| smiSvcOk | input | 1 | High while the interrupt handler is servicing its requests |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of a 32-bit register |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data, combinational from `addr` |
| smiReq | output | 1 | Management-interrupt request, one cycle per expiry |
| sysRst | output | 1 | Registered system-reset pulse |

## Verification
The embedded assertions check the rules that hold on every cycle:
- A reset pulse only starts when the flag was already set.
- An interrupt request only follows an enabled expiry.
- A serviced request clears the flag on the next edge.
- A kick reloads the counter and keeps the flag.
- A disarmed counter holds its value.
- The end of a pulse restores the control bits.

The following need the bench's scenarios, which sweep the timeout over several small values:
- The arithmetic hang time of 2T ticks.
- The exact pulse length.
- Servicing over many periods.
- A hung handler.
- The timeout-zero corner.
- Writes ignored during the pulse.

// File: rtl/twostrike_pkg.sv
package twostrike_pkg;

  localparam int ADDR_W = 5;

  // Register byte offsets (32-bit registers)
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TIMEOUT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_SMICFG  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_COUNT   = 5'h10;

  // Field positions
  localparam int BIT_ARM     = 0;
  localparam int BIT_EXPIRED = 3;
  localparam int BIT_SMICLR  = 13;

  // Strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic dec;
    logic setFlag;
    logic clrFlag;
    logic initAll;
    logic wrTimeout;
  } wdStrb_t;

endpackage

// File: rtl/twostrike_dpath.sv
module twostrike_dpath
  import twostrike_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int DEF_TIMEOUT = 300
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrb_t          strb,
  input  logic [TMR_W-1:0] wrVal,
  output logic [TMR_W-1:0] timeoutVal,
  output logic [TMR_W-1:0] cntVal,
  output logic             cntLow,
  output logic             flagQ
);

  localparam logic [TMR_W-1:0] DEF_VAL = TMR_W'(DEF_TIMEOUT);
  localparam logic [TMR_W-1:0] ONE_VAL = TMR_W'(1);

  logic [TMR_W-1:0] timeoutReg;
  logic [TMR_W-1:0] cntReg;
  logic             flagReg;

  // Counter at 1 or 0: the next tick is an expiry
  assign cntLow     = cntReg <= ONE_VAL;
  assign timeoutVal = timeoutReg;
  assign cntVal     = cntReg;
  assign flagQ      = flagReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutReg <= DEF_VAL;
      cntReg     <= DEF_VAL;
      flagReg    <= 1'b0;
    end else if (strb.initAll) begin
      timeoutReg <= DEF_VAL;
      cntReg     <= DEF_VAL;
      flagReg    <= 1'b0;
    end else begin
      if (strb.wrTimeout) timeoutReg <= wrVal;

      if (strb.reload)   cntReg <= timeoutReg;
      else if (strb.dec) cntReg <= cntReg - ONE_VAL;

      // A new expiry wins over any clear in the same cycle
      if (strb.setFlag)      flagReg <= 1'b1;
      else if (strb.clrFlag) flagReg <= 1'b0;
    end
  end

endmodule

// File: rtl/twostrike_ctrl.sv
module twostrike_ctrl
  import twostrike_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              kick,
  input  logic              smiSvcOk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              cntLow,
  input  logic              flagQ,
  input  logic [TMR_W-1:0]  timeoutVal,
  input  logic [TMR_W-1:0]  cntVal,
  output wdStrb_t           strb,
  output logic [31:0]       rdData,
  output logic              smiReq,
  output logic              sysRst
);

  localparam int RCNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [RCNT_W-1:0] RCNT_LOAD = RCNT_W'(RST_CYCLES);
  localparam logic [RCNT_W-1:0] RCNT_ONE  = RCNT_W'(1);

  logic              armEn;
  logic              smiEn;
  logic              smiReqQ;
  logic              sysRstQ;
  logic [RCNT_W-1:0] rstCnt;

  logic rstActive;
  logic swWrCtrl, swWrStatus, swWrTimeout, swWrSmi;
  logic armRise, expire, strike2, autoClr;
  logic unusedWrBits;

  assign rstActive   = rstCnt != '0;
  assign swWrCtrl    = wrEn && (addr == OFS_CTRL)    && !rstActive;
  assign swWrStatus  = wrEn && (addr == OFS_STATUS)  && !rstActive;
  assign swWrTimeout = wrEn && (addr == OFS_TIMEOUT) && !rstActive;
  assign swWrSmi     = wrEn && (addr == OFS_SMICFG)  && !rstActive;

  assign armRise = swWrCtrl && wrData[BIT_ARM] && !armEn;
  assign expire  = armEn && tick && !kick && cntLow && !rstActive;
  assign strike2 = expire && flagQ;
  assign autoClr = smiReqQ && smiSvcOk && !rstActive;

  always_comb begin
    strb           = '0;
    strb.reload    = !rstActive && (kick || armRise || expire);
    strb.dec       = !rstActive && armEn && tick && !kick && !cntLow;
    strb.setFlag   = expire;
    strb.clrFlag   = autoClr || (swWrStatus && wrData[BIT_EXPIRED]);
    strb.initAll   = rstCnt == RCNT_ONE;
    strb.wrTimeout = swWrTimeout;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armEn   <= 1'b0;
      smiEn   <= 1'b1;
      smiReqQ <= 1'b0;
      sysRstQ <= 1'b0;
      rstCnt  <= '0;
    end else begin
      smiReqQ <= expire && smiEn;

      if (strb.initAll) begin
        armEn <= 1'b0;
        smiEn <= 1'b1;
      end else begin
        if (swWrCtrl) armEn <= wrData[BIT_ARM];
        if (swWrSmi)  smiEn <= wrData[BIT_SMICLR];
      end

      if (strike2) begin
        rstCnt  <= RCNT_LOAD;
        sysRstQ <= 1'b1;
      end else if (rstActive) begin
        rstCnt <= rstCnt - RCNT_ONE;
        if (strb.initAll) sysRstQ <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      OFS_CTRL:    rdData[BIT_ARM]     = armEn;
      OFS_STATUS:  rdData[BIT_EXPIRED] = flagQ;
      OFS_TIMEOUT: rdData              = 32'(timeoutVal);
      OFS_SMICFG:  rdData[BIT_SMICLR]  = smiEn;
      OFS_COUNT:   rdData              = 32'(cntVal);
      default:     rdData              = '0;
    endcase
  end

  assign smiReq = smiReqQ;
  assign sysRst = sysRstQ;

  assign unusedWrBits = ^{wrData[31:BIT_SMICLR+1], wrData[BIT_SMICLR-1:BIT_EXPIRED+1],
                          wrData[BIT_EXPIRED-1:BIT_ARM+1]};

  AST_RST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRst) |-> $past(flagQ)); // R4

  AST_SMI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smiReq) |-> $past(smiEn)); // R6

  AST_SMI_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    smiReq && smiSvcOk && !sysRst && !(tick && armEn) |=> !flagQ); // R6

  AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    kick && !sysRst |=> cntVal == $past(timeoutVal)); // R5

  AST_KICK_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    kick && flagQ && !sysRst && !smiReq && !wrEn |=> flagQ); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !armEn && !kick && !wrEn && !sysRst |=> $stable(cntVal)); // R9

  AST_PULSE_END_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRst) |-> !armEn && smiEn && !flagQ); // R8

endmodule

// File: rtl/twostrike_wdog.sv
module twostrike_wdog
  import twostrike_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int RST_CYCLES  = 16,
  parameter int DEF_TIMEOUT = 300
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        kick,
  input  logic        smiSvcOk,
  input  logic        wrEn,
  input  logic [4:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        smiReq,
  output logic        sysRst
);

  wdStrb_t          strb;
  logic [TMR_W-1:0] timeoutVal;
  logic [TMR_W-1:0] cntVal;
  logic             cntLow;
  logic             flagQ;

  twostrike_ctrl #(
    .TMR_W      (TMR_W),
    .RST_CYCLES (RST_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .kick       (kick),
    .smiSvcOk   (smiSvcOk),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .cntLow     (cntLow),
    .flagQ      (flagQ),
    .timeoutVal (timeoutVal),
    .cntVal     (cntVal),
    .strb       (strb),
    .rdData     (rdData),
    .smiReq     (smiReq),
    .sysRst     (sysRst)
  );

  twostrike_dpath #(
    .TMR_W       (TMR_W),
    .DEF_TIMEOUT (DEF_TIMEOUT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrVal      (wrData[TMR_W-1:0]),
    .timeoutVal (timeoutVal),
    .cntVal     (cntVal),
    .cntLow     (cntLow),
    .flagQ      (flagQ)
  );

endmodule

// File: tb/twostrike_wdog_bench.sv
`timescale 1ns/1ps
module twostrike_wdog_bench;

  localparam int TB_W   = 8;
  localparam int TB_RST = 4;
  localparam int TB_DEF = 9;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_TMO = 5'h08,
                         A_SMI = 5'h0C, A_CNT = 5'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        kick = 1'b0;
  logic        smiSvcOk = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        smiReq;
  logic        sysRst;

  int vecs = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  twostrike_wdog #(
    .TMR_W(TB_W), .RST_CYCLES(TB_RST), .DEF_TIMEOUT(TB_DEF)
  ) u_twostrike_wdog (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .smiSvcOk(smiSvcOk),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .smiReq(smiReq), .sysRst(sysRst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tickOnce();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic kickOnce();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    while (sysRst === 1'b1 && n < 64) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v0;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 sysRst", {31'b0, sysRst}, 0);
    chk("R1 smiReq", {31'b0, smiReq}, 0);
    rd(A_CTRL, v); chk("R1 arm", v, 0);
    rd(A_STAT, v); chk("R1 flag", v, 0);
    rd(A_TMO, v);  chk("R1 timeout", v, TB_DEF);
    rd(A_CNT, v);  chk("R1 count", v, TB_DEF);
    rd(A_SMI, v);  chk("R1 smi enable", v, 32'h2000);

    // R2/R4/R8: sweep of timeouts, hang detected at tick 2T
    for (int t = 1; t <= 5; t++) begin
      wr(A_SMI, 0);
      wr(A_TMO, t);
      wr(A_CTRL, 1);
      for (int i = 1; i <= 2 * t; i++) begin
        tickOnce();
        if (i == t) begin
          rd(A_STAT, v); chk("R2 flag after T ticks", v, 8);
        end
        if (i < t) begin
          rd(A_CNT, v); chk("R2 count decrements", v, t - i);
        end
        chk(i == 2 * t ? "R4 reset at second strike" : "R4 no early reset",
            {31'b0, sysRst}, 32'(i == 2 * t));
      end
      waitPulse(n);
      chk("R4 pulse length", n, TB_RST);
      rd(A_CTRL, v); chk("R8 arm cleared", v, 0);
      rd(A_STAT, v); chk("R8 flag cleared", v, 0);
      rd(A_SMI, v);  chk("R8 smi enable restored", v, 32'h2000);
      rd(A_TMO, v);  chk("R8 timeout restored", v, TB_DEF);
      rd(A_CNT, v);  chk("R8 count restored", v, TB_DEF);
    end

    // R10: timeout zero acts as one; R9: writes during pulse ignored
    wr(A_SMI, 0);
    wr(A_TMO, 0);
    wr(A_CTRL, 1);
    tickOnce();
    rd(A_STAT, v); chk("R10 first tick expires", v, 8);
    chk("R10 no reset yet", {31'b0, sysRst}, 0);
    tickOnce();
    chk("R10 second tick resets", {31'b0, sysRst}, 1);
    wr(A_TMO, 32'h55);
    wr(A_CTRL, 1);
    waitPulse(n);
    chk("R4 pulse length after writes", n + 2, TB_RST);
    rd(A_TMO, v);  chk("R9 timeout write ignored in pulse", v, TB_DEF);
    rd(A_CTRL, v); chk("R9 arm write ignored in pulse", v, 0);

    // R3: software servicing with write-one-to-clear
    wr(A_SMI, 0);
    wr(A_TMO, 3);
    wr(A_CTRL, 1);
    for (int p = 0; p < 4; p++) begin
      repeat (3) tickOnce();
      rd(A_STAT, v); chk("R3 flag set", v, 8);
      wr(A_STAT, 32'hFFFF_FFF7);
      rd(A_STAT, v); chk("R3 bit3 clear leaves flag", v, 8);
      wr(A_STAT, 32'h8);
      rd(A_STAT, v); chk("R3 bit3 set clears flag", v, 0);
      kickOnce();
      chk("R3 no reset while serviced", {31'b0, sysRst}, 0);
    end
    wr(A_CTRL, 0);

    // R9: disarmed counter ignores ticks
    rd(A_CNT, v0);
    repeat (5) tickOnce();
    rd(A_CNT, v); chk("R9 count held when disarmed", v, v0);
    rd(A_STAT, v); chk("R9 no flag when disarmed", v, 0);

    // R5: kick reloads without clearing the flag
    wr(A_TMO, 4);
    wr(A_CTRL, 1);
    repeat (4) tickOnce();
    rd(A_STAT, v); chk("R5 flag before kick", v, 8);
    kickOnce();
    rd(A_CNT, v);  chk("R5 kick reloads count", v, 4);
    rd(A_STAT, v); chk("R5 kick keeps flag", v, 8);
    repeat (3) tickOnce();
    chk("R5 no reset before full period", {31'b0, sysRst}, 0);
    rd(A_CNT, v); chk("R5 count after three ticks", v, 1);
    tickOnce();
    chk("R5 reset at full period", {31'b0, sysRst}, 1);
    waitPulse(n);

    // R6: interrupt path services the flag
    wr(A_TMO, 2);
    wr(A_CTRL, 1);
    tickOnce();
    @(negedge clk);
    tickOnce();
    chk("R6 smiReq on expiry", {31'b0, smiReq}, 1);
    rd(A_STAT, v); chk("R6 flag on expiry", v, 8);
    @(negedge clk);
    chk("R6 smiReq one cycle", {31'b0, smiReq}, 0);
    rd(A_STAT, v); chk("R6 flag auto cleared", v, 0);
    for (int k = 0; k < 10; k++) begin
      tickOnce();
      @(negedge clk);
      chk("R6 serviced never resets", {31'b0, sysRst}, 0);
    end

    // R7: hung handler leads to reset
    smiSvcOk = 1'b0;
    wr(A_CTRL, 0);
    wr(A_CTRL, 1);
    tickOnce();
    tickOnce();
    chk("R7 smiReq raised", {31'b0, smiReq}, 1);
    @(negedge clk);
    rd(A_STAT, v); chk("R7 flag not cleared", v, 8);
    tickOnce();
    chk("R7 no reset mid period", {31'b0, sysRst}, 0);
    tickOnce();
    chk("R7 reset on second strike", {31'b0, sysRst}, 1);
    waitPulse(n);
    chk("R7 pulse length", n, TB_RST);
    smiSvcOk = 1'b1;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule